// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block turns a 32768 Hz tick strobe into periodic events whose spacing is picked by a 4-bit rate code. A 15-bit tick counter advances on every strobe. An event fires on the strobe that carries the counter onto a multiple of the selected period, so events stay aligned to a fixed grid and never land part-way through a period.

Each event produces a one-cycle flag-set pulse. The interrupt-request pulse follows only when the periodic interrupt enable is high. The square-wave pulse follows only when the square-wave enable is high; it is a short pulse, not a half-duty waveform. The surrounding register file decodes the rate code and the enables and latches the pulses into its own status flags. A divider-reset input clears the counter to zero and keeps it there.

Top module: `ppd_divider`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, flag_set_o, irq_set_o and sqw_pulse_o are all 0, and the tick counter starts from 0.
- R2: With rate_code equal to 0, no pulse appears on any output, whatever the enables and ticks are.
- R3: For rate_code values 3 to 15, the period is 2^(rate_code-1) ticks: 4 ticks for code 3, up to 16384 ticks for code 15.
- R4: rate_code 1 gives a period of 128 ticks and rate_code 2 gives 256 ticks, the same periods as codes 8 and 9.
- R5: An event happens on the tick that moves the 15-bit counter (wrapping modulo 32768) to a value that is a multiple of the period. The counter counts every tick while div_reset is low, even when no events are enabled.
- R6: When periodic_en and sqw_en are both 0, no pulse appears on any output.
- R7: Every event raises flag_set_o. irq_set_o is raised together with it exactly when periodic_en is 1.
- R8: sqw_pulse_o is raised together with flag_set_o exactly when sqw_en is 1. It lasts one cycle per event.
- R9: A new rate_code takes effect at once: the next event falls on the next multiple of the new period. No event is produced for the unfinished old period.
- R10: While div_reset is 1, the counter is held at 0 and no event occurs. After div_reset falls, the first event comes after one full period of ticks.
- R11: A pulse appears in the clock cycle right after the edge that samples the qualifying tick, and it lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle strobe at 32768 Hz |
| div_reset | input | 1 | Holds the tick counter at zero and stops events |
| rate_code | input | 4 | Period select; 0 turns events off |
| periodic_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave pulse enable |
| flag_set_o | output | 1 | Pulse that sets the periodic flag |
| irq_set_o | output | 1 | Pulse that sets the interrupt request flag |
| sqw_pulse_o | output | 1 | Square-wave output pulse |

## Verification
The only internal state is the tick counter. A wrong count shows up as an event on the wrong tick, and the error repeats with every period after it. The bench keeps its own counter and compares all three outputs every cycle. A counter or period fault is therefore reported at the first event it moves. For the 4-tick period that is within four ticks; for the slowest rate it can take up to 16384 ticks. A wrong enable qualifier shows up one cycle after the first event, on irq_set_o or sqw_pulse_o.

// File: rtl/ppd_pkg.sv
`timescale 1ns/1ps
package ppd_pkg;

  // Codes at or below this limit are moved up the table by RATE_ALIAS_STEP.
  localparam int unsigned RATE_ALIAS_LIMIT = 2;
  localparam int unsigned RATE_ALIAS_STEP  = 7;

  // log2 of the period in ticks for a rate code; 0 for the off code.
  function automatic int unsigned rate_shift(input int unsigned code);
    int unsigned eff;
    if (code == 0) return 0;
    eff = (code <= RATE_ALIAS_LIMIT) ? code + RATE_ALIAS_STEP : code;
    return eff - 1;
  endfunction

  // True when the low 'shift' bits of value are all zero.
  function automatic logic on_boundary(input logic [31:0] value,
                                       input int unsigned shift);
    logic [31:0] low_bits;
    low_bits = (32'd1 << shift) - 32'd1;
    return (value & low_bits) == 32'd0;
  endfunction

endpackage

// File: rtl/ppd_tick_counter.sv
`timescale 1ns/1ps
module ppd_tick_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hold,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] count_inc
);
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO = '0;

  // Counter value after the current tick, wrapping at 2^CNT_W.
  assign count_inc = count_q + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= ZERO;
    end else if (hold) begin
      count_q <= ZERO;
    end else if (tick) begin
      count_q <= count_inc;
    end
  end
endmodule

// File: rtl/ppd_boundary.sv
`timescale 1ns/1ps
module ppd_boundary #(
  parameter int CNT_W  = 15,
  parameter int CODE_W = 4
) (
  input  logic              tick,
  input  logic              hold,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              periodic_en,
  input  logic              sqw_en,
  input  logic [CNT_W-1:0]  count_inc,
  output logic              rate_active,
  output logic              event_hit
);
  import ppd_pkg::*;

  localparam logic [CODE_W-1:0] CODE_OFF = '0;

  int unsigned shift;

  assign shift       = rate_shift(32'(rate_code));
  assign rate_active = (rate_code != CODE_OFF) && (periodic_en || sqw_en) && !hold;
  // The counter moves by one, so the next multiple of the period is reached
  // exactly when the incremented count has its low bits clear.
  assign event_hit   = rate_active && tick && on_boundary(32'(count_inc), shift);
endmodule

// File: rtl/ppd_route.sv
`timescale 1ns/1ps
module ppd_route #(
  parameter int N_OUT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             event_hit,
  input  logic [N_OUT-1:0] qualify,
  output logic [N_OUT-1:0] pulse_q
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_pulse
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pulse_q[i] <= 1'b0;
      end else begin
        pulse_q[i] <= event_hit && qualify[i];
      end
    end
  end
endmodule

// File: rtl/ppd_divider.sv
`timescale 1ns/1ps
module ppd_divider #(
  parameter int CNT_W  = 15,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic              div_reset,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              periodic_en,
  input  logic              sqw_en,
  output logic              flag_set_o,
  output logic              irq_set_o,
  output logic              sqw_pulse_o
);
  localparam int N_OUT = 3;

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_inc;
  logic             rate_active;
  logic             event_hit;
  logic [N_OUT-1:0] qualify;
  logic [N_OUT-1:0] pulse_q;

  ppd_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_32k),
    .hold      (div_reset),
    .count_q   (count_q),
    .count_inc (count_inc)
  );

  ppd_boundary #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_bnd (
    .tick        (tick_32k),
    .hold        (div_reset),
    .rate_code   (rate_code),
    .periodic_en (periodic_en),
    .sqw_en      (sqw_en),
    .count_inc   (count_inc),
    .rate_active (rate_active),
    .event_hit   (event_hit)
  );

  // Bit 0: flag, always; bit 1: interrupt request; bit 2: square-wave pulse.
  assign qualify = {sqw_en, periodic_en, 1'b1};

  ppd_route #(.N_OUT(N_OUT)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .event_hit (event_hit),
    .qualify   (qualify),
    .pulse_q   (pulse_q)
  );

  assign flag_set_o  = pulse_q[0];
  assign irq_set_o   = pulse_q[1];
  assign sqw_pulse_o = pulse_q[2];
endmodule

// File: rtl/ppd_checker.sv
`timescale 1ns/1ps
module ppd_checker #(
  parameter int CNT_W  = 15,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              div_reset,
  input logic [CODE_W-1:0] rate_code,
  input logic              periodic_en,
  input logic              sqw_en,
  input logic              flag_set_o,
  input logic              irq_set_o,
  input logic              sqw_pulse_o,
  input logic [CNT_W-1:0]  count_q
);
  import ppd_pkg::*;

  assert_code_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == '0) |=> !flag_set_o);

  assert_enables_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!periodic_en && !sqw_en) |=> !flag_set_o);

  assert_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set_o |-> on_boundary(32'(count_q), rate_shift(32'($past(rate_code)))));

  assert_irq_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set_o |-> (flag_set_o && $past(periodic_en)));

  assert_sqw_qual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse_o |-> (flag_set_o && $past(sqw_en)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    div_reset |=> (!flag_set_o && count_q == '0));

  assert_single_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set_o |=> !flag_set_o);
endmodule

bind ppd_divider ppd_checker #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .div_reset   (div_reset),
  .rate_code   (rate_code),
  .periodic_en (periodic_en),
  .sqw_en      (sqw_en),
  .flag_set_o  (flag_set_o),
  .irq_set_o   (irq_set_o),
  .sqw_pulse_o (sqw_pulse_o),
  .count_q     (count_q)
);

// File: tb/sim_ppd_divider.sv
`timescale 1ns/1ps
module sim_ppd_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       dres = 1'b0;
  logic [3:0] code = 4'd0;
  logic       pen = 1'b0;
  logic       sen = 1'b0;
  logic       flag, irq, sqw;

  int    checks = 0;
  int    errors = 0;
  int    mcnt = 0;
  bit    done = 1'b0;
  string req = "R1";

  always #2.5 clk = ~clk;

  ppd_divider u0 (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick), .div_reset(dres),
    .rate_code(code), .periodic_en(pen), .sqw_en(sen),
    .flag_set_o(flag), .irq_set_o(irq), .sqw_pulse_o(sqw)
  );

  // Period in ticks, computed from the requirement text (R3, R4).
  function automatic int model_period(int c);
    int p;
    if (c == 0) return 0;
    if (c == 1) return 128;
    if (c == 2) return 256;
    p = 1;
    for (int k = 1; k < c; k++) p = p * 2;
    return p;
  endfunction

  task automatic compare(logic [2:0] exp);
    logic [2:0] got;
    got = {flag, irq, sqw};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got{flag,irq,sqw}=%b expected=%b code=%0d cnt=%0d",
               req, got, exp, code, mcnt);
    end
  endtask

  // Called at a falling edge: drive the tick, predict, then sample one cycle on.
  task automatic step(bit t);
    int p;
    bit ev;
    tick = t;
    p  = model_period(int'(code));
    ev = !dres && t && (p != 0) && (pen || sen) && (((mcnt + 1) % p) == 0);
    if (dres) mcnt = 0;
    else if (t) mcnt = (mcnt + 1) % 32768;
    @(posedge clk);
    @(negedge clk);
    compare({ev, ev && pen, ev && sen});
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(1'b1);
  endtask

  initial begin
    // R1: reset state
    req = "R1";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare(3'b000);
    end
    code = 4'd3; pen = 1'b1; sen = 1'b1;
    rst_n = 1'b1;
    mcnt = 0;
    step(1'b0);

    // R10: divider reset holds the counter and blocks events
    req = "R10"; dres = 1'b1;
    run(6);
    dres = 1'b0;
    // R5: first events at counts 4, 8, 12 after the hold is released
    req = "R5";
    run(13);

    // R2: off code
    req = "R2"; code = 4'd0;
    run(64);

    // R6, R7, R8: every enable combination at a 4-tick period
    code = 4'd3;
    req = "R6"; pen = 1'b0; sen = 1'b0; run(40);
    req = "R7"; pen = 1'b1; sen = 1'b0; run(40);
    req = "R8"; pen = 1'b0; sen = 1'b1; run(40);
    req = "R7_R8"; pen = 1'b1; sen = 1'b1; run(40);

    // R3: codes 3..15, two full periods each
    req = "R3"; pen = 1'b1; sen = 1'b0;
    for (int c = 3; c < 16; c++) begin
      code = 4'(c);
      run(2 * model_period(c) + 3);
    end

    // R4: aliased codes 1 and 2
    req = "R4"; pen = 1'b0; sen = 1'b1;
    for (int c = 1; c < 3; c++) begin
      code = 4'(c);
      run(2 * model_period(c) + 3);
    end

    // R9: rate changes in the middle of a period
    req = "R9"; pen = 1'b1; sen = 1'b1;
    code = 4'd6; run(21);
    code = 4'd3; run(19);
    code = 4'd9; run(300);
    code = 4'd4; run(11);

    // R11: sparse ticks, pulses only after the qualifying tick, one cycle wide
    req = "R11"; code = 4'd4;
    for (int i = 0; i < 240; i++) step((i % 3) == 0);

    // R10: hold in the middle of a run, then one full period to the next event
    req = "R10"; code = 4'd4;
    run(5);
    dres = 1'b1; run(3);
    dres = 1'b0; run(40);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired during %s", req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule